// File: doc/BRIEF.md
# Ambient-Light Sensor I2C Target

This block is the bus side of a 16-bit ambient-light sensor. It is an I2C target that watches the SCL and SDA lines and pulls SDA low through an output-enable. A controller writes one-byte mode commands to it and reads back a 16-bit light count as two bytes. The count itself arrives on an input port, which stands in for the optical front end.

A measurement command starts an internal timer. The first result is latched a set number of clock cycles after the command. In continuous mode the result is then refreshed once every refresh period. In one-shot mode the block latches one result. Once that result has been read, it falls back to power-down by itself.

A strap pin picks one of two 7-bit addresses, so two sensors can share one bus. Status outputs show the current mode and whether a fresh result is available.

Top module: `light_sensor_target`

## Requirements
- R1: The 7-bit address is 0x5C (1011100) when `addr_strap` is 1 and 0x23 (0100011) when it is 0; only the selected address is acknowledged.
- R2: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) are detected. The target acknowledges its address and every written byte by driving SDA low during the ninth clock.
- R3: After an address that does not match, the target leaves SDA released and ignores the bus until the next START or STOP.
- R4: A read returns the result as two bytes, MSB first, with bits 15..8 first. The target samples the controller's acknowledge after each byte, and stops driving once it sees a not-acknowledge after the final byte.
- R5: Command 0x10 selects continuous mode. It clears `ready_o`, latches the first result FIRST_DELAY cycles later, and then re-latches `sample_value` every REFRESH cycles with no further command.
- R6: Command 0x20 selects one-shot mode. Exactly one result is latched after FIRST_DELAY cycles. Once the controller has finished reading that result, the mode returns to power-down, and no further result is latched.
- R7: Command 0x00 selects power-down, which stops refreshing. Command 0x01 selects powered idle. Any other byte is acknowledged and leaves the mode unchanged.
- R8: A read before a result is ready returns the last latched value, which is 0x0000 after reset.
- R9: `mode_o` encodes 0 = power-down, 1 = continuous, 2 = one-shot, 3 = powered idle. `ready_o` is 1 while a result latched since the last measurement command is held. After reset the mode is 0, `ready_o` is 0 and `sda_oe` is 0.
- R10: The target changes `sda_oe` only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| addr_strap | input | 1 | Address select strap |
| sample_value | input | 16 | Raw light count from the front end |
| sda_oe | output | 1 | 1 pulls SDA low |
| mode_o | output | 2 | Current mode code |
| ready_o | output | 1 | Fresh result held |

## Verification
The assertions check three things on every cycle:
- SDA is only switched while SCL is low.
- A measurement command clears the ready flag.
- Ready only rises in a measuring mode, an unknown command leaves the mode unchanged, and reading a one-shot result powers the block down.

Only the bench's transactions can show the rest: address selection by the strap, the bit order of the returned bytes, the timing of the first and later results, and that power-down and one-shot mode stop refreshing. The bench shows these by comparing read values against the values it expects.

// File: rtl/lst_pkg.sv
package lst_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_CONT = 2'd1,
        MODE_ONE  = 2'd2,
        MODE_IDLE = 2'd3
    } lst_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_IGNORE
    } lst_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    localparam logic [7:0] CMD_OFF  = 8'h00;
    localparam logic [7:0] CMD_ON   = 8'h01;
    localparam logic [7:0] CMD_CONT = 8'h10;
    localparam logic [7:0] CMD_ONE  = 8'h20;

    function automatic logic [6:0] target_addr(input logic strap);
        return strap ? 7'h5C : 7'h23;
    endfunction

endpackage

// File: rtl/lst_bus_sync.sv
module lst_bus_sync
    import lst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t ev
);
    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic scl_q, sda_q, scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s = scl_ff[SYNC_STAGES-1];
    assign sda_s = sda_ff[SYNC_STAGES-1];

    always_comb begin
        ev.scl   = scl_s;
        ev.sda   = sda_s;
        ev.start = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop  = scl_s & scl_q & ~sda_q & sda_s;
        ev.rise  = scl_s & ~scl_q;
        ev.fall  = ~scl_s & scl_q;
    end
endmodule

// File: rtl/lst_i2c_engine.sv
module lst_i2c_engine
    import lst_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          ev,
    input  logic              strap,
    input  logic [DATA_W-1:0] data_i,
    output logic              sda_oe,
    output logic              cmd_valid,
    output logic [7:0]        cmd_byte,
    output logic              read_done
);
    lst_state_e state;
    logic [2:0] cnt;
    logic       full;
    logic [7:0] shreg;
    logic [7:0] lo_hold;
    logic       is_read;
    logic       idx;
    logic       ack_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            full      <= 1'b0;
            shreg     <= '0;
            lo_hold   <= '0;
            is_read   <= 1'b0;
            idx       <= 1'b0;
            ack_ok    <= 1'b0;
            sda_oe    <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
            read_done <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            read_done <= 1'b0;
            if (ev.start) begin
                state  <= ST_ADDR;
                cnt    <= '0;
                full   <= 1'b0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (ev.rise && !full) begin
                            shreg <= {shreg[6:0], ev.sda};
                            cnt   <= cnt + 3'd1;
                            if (cnt == 3'd7) full <= 1'b1;
                        end else if (ev.fall && full) begin
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == target_addr(strap)) begin
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ADDR_ACK;
                                    is_read <= shreg[0];
                                    idx     <= 1'b0;
                                    if (shreg[0]) begin
                                        shreg   <= data_i[DATA_W-1 -: 8];
                                        lo_hold <= data_i[7:0];
                                    end
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else begin
                                sda_oe    <= 1'b1;
                                cmd_valid <= 1'b1;
                                cmd_byte  <= shreg;
                                state     <= ST_WR_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.fall) begin
                            cnt  <= '0;
                            full <= 1'b0;
                            if (is_read) begin
                                sda_oe <= ~shreg[7];
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (ev.fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            full   <= 1'b0;
                            state  <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (ev.rise && !full) begin
                            cnt <= cnt + 3'd1;
                            if (cnt == 3'd7) full <= 1'b1;
                        end else if (ev.fall) begin
                            if (full) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (ev.rise) begin
                            ack_ok <= ~ev.sda;
                            if (idx) read_done <= 1'b1;
                        end else if (ev.fall) begin
                            if (ack_ok && !idx) begin
                                shreg  <= lo_hold;
                                sda_oe <= ~lo_hold[7];
                                idx    <= 1'b1;
                                cnt    <= '0;
                                full   <= 1'b0;
                                state  <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: the target only switches SDA while SCL is low
    assert_sda_lowscl_R10: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_oe) && !$past(ev.start) && !$past(ev.stop)) |-> !$past(ev.scl));

    // R3: once ignoring the bus, SDA stays released
    assert_ignore_release_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE && $past(state) == ST_IGNORE) |-> !sda_oe);

    // R2: a START always restarts address reception
    assert_start_addr_R2: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR && !sda_oe));
endmodule

// File: rtl/lst_meas_ctrl.sv
module lst_meas_ctrl
    import lst_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int FIRST_DELAY = 45_000_000,
    parameter int REFRESH     = 30_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_byte,
    input  logic              read_done,
    input  logic [DATA_W-1:0] sample_value,
    output logic [DATA_W-1:0] result,
    output lst_mode_e         mode,
    output logic              ready
);
    localparam int MAX_DELAY = (FIRST_DELAY > REFRESH) ? FIRST_DELAY : REFRESH;
    localparam int TW        = $clog2(MAX_DELAY + 1);

    logic [TW-1:0] timer;
    logic          counting;

    assign counting = (mode == MODE_CONT) || (mode == MODE_ONE && !ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MODE_OFF;
            timer  <= '0;
            result <= '0;
            ready  <= 1'b0;
        end else if (cmd_valid) begin
            case (cmd_byte)
                CMD_CONT: begin
                    mode  <= MODE_CONT;
                    timer <= TW'(FIRST_DELAY - 1);
                    ready <= 1'b0;
                end
                CMD_ONE: begin
                    mode  <= MODE_ONE;
                    timer <= TW'(FIRST_DELAY - 1);
                    ready <= 1'b0;
                end
                CMD_OFF: mode <= MODE_OFF;
                CMD_ON:  mode <= MODE_IDLE;
                default: ;
            endcase
        end else if (read_done && mode == MODE_ONE && ready) begin
            mode <= MODE_OFF;
        end else if (counting) begin
            if (timer == '0) begin
                result <= sample_value;
                ready  <= 1'b1;
                if (mode == MODE_CONT) timer <= TW'(REFRESH - 1);
            end else begin
                timer <= timer - 1'b1;
            end
        end
    end

    // R5: a measurement command clears the ready flag
    assert_cmd_clears_ready_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_byte == CMD_CONT || cmd_byte == CMD_ONE)) |=> !ready);

    // R5: a new result only appears in a measuring mode
    assert_ready_src_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (mode == MODE_CONT || mode == MODE_ONE));

    // R6: reading a held one-shot result powers the block down
    assert_oneshot_off_R6: assert property (@(posedge clk) disable iff (rst)
        (read_done && mode == MODE_ONE && ready && !cmd_valid) |=> mode == MODE_OFF);

    // R7: an unknown command byte leaves the mode unchanged
    assert_unknown_cmd_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_byte != CMD_CONT && cmd_byte != CMD_ONE &&
         cmd_byte != CMD_OFF && cmd_byte != CMD_ON) |=> $stable(mode));
endmodule

// File: rtl/light_sensor_target.sv
module light_sensor_target
    import lst_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int FIRST_DELAY = 45_000_000,
    parameter int REFRESH     = 30_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_strap,
    input  logic [DATA_W-1:0] sample_value,
    output logic              sda_oe,
    output logic [1:0]        mode_o,
    output logic              ready_o
);
    bus_evt_t          ev;
    logic              cmd_valid;
    logic [7:0]        cmd_byte;
    logic              read_done;
    logic [DATA_W-1:0] result;
    lst_mode_e         mode;

    lst_bus_sync #(.SYNC_STAGES(2)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    lst_i2c_engine #(.DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .strap     (addr_strap),
        .data_i    (result),
        .sda_oe    (sda_oe),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .read_done (read_done)
    );

    lst_meas_ctrl #(
        .DATA_W      (DATA_W),
        .FIRST_DELAY (FIRST_DELAY),
        .REFRESH     (REFRESH)
    ) u_meas (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_byte     (cmd_byte),
        .read_done    (read_done),
        .sample_value (sample_value),
        .result       (result),
        .mode         (mode),
        .ready        (ready_o)
    );

    assign mode_o = mode;
endmodule

// File: tb/light_sensor_target_bench.sv
module light_sensor_target_bench;
    localparam int FIRST = 1500;
    localparam int PER   = 1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        m_low = 1'b0;
    logic        strap = 1'b0;
    logic [15:0] sample = 16'h0000;
    logic        sda_oe;
    logic [1:0]  mode_o;
    logic        ready_o;
    wire         sda_line = ~(m_low | sda_oe);

    int errors = 0;
    int checks = 0;
    logic [15:0] exp_q[$];
    logic [15:0] got_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    light_sensor_target #(.FIRST_DELAY(FIRST), .REFRESH(PER)) u_light_sensor_target (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .addr_strap(strap),
        .sample_value(sample), .sda_oe(sda_oe), .mode_o(mode_o), .ready_o(ready_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: compares each finished read with the expected item
    always @(negedge clk) begin
        if (got_q.size() != 0 && exp_q.size() != 0) begin
            logic [15:0] g, e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(g == e, t, g, e);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; scl = 1'b1; tick(4);
        m_low = 1'b1; tick(4);
        scl = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(4);
        scl = 1'b1; tick(4);
        m_low = 1'b0; tick(8);
    endtask

    task automatic send_bit(input logic b);
        m_low = ~b; tick(4);
        scl = 1'b1; tick(8);
        scl = 1'b0; tick(4);
    endtask

    task automatic recv_bit(output logic b);
        m_low = 1'b0; tick(4);
        scl = 1'b1; tick(4);
        b = sda_line; tick(4);
        scl = 1'b0; tick(4);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(ack);
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic nack);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            recv_bit(b);
            v[i] = b;
        end
        send_bit(nack);
    endtask

    task automatic write_cmd(input logic [6:0] a, input logic [7:0] c,
                             output logic a1, output logic a2);
        bus_start();
        send_byte({a, 1'b0}, a1);
        a2 = 1'b1;
        if (!a1) send_byte(c, a2);
        bus_stop();
    endtask

    // driver: pushes the expected value, performs the read, hands result to monitor
    task automatic read_val(input logic [6:0] a, input logic [15:0] exp, input string tag);
        logic ack;
        logic [7:0] hi, lo;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_start();
        send_byte({a, 1'b1}, ack);
        chk(ack == 1'b0, {tag, " address ack"}, ack, 0);
        recv_byte(hi, 1'b0);
        recv_byte(lo, 1'b1);
        tick(2);
        chk(sda_oe == 1'b0, "R4 released after final not-acknowledge", sda_oe, 0);
        bus_stop();
        got_q.push_back({hi, lo});
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic a1, a2;
        tick(5);
        rst = 1'b0;
        tick(2);
        chk(mode_o == 2'd0, "R9 reset mode", mode_o, 0);
        chk(ready_o == 1'b0, "R9 reset ready", ready_o, 0);
        chk(sda_oe == 1'b0, "R9 reset sda_oe", sda_oe, 0);

        read_val(7'h23, 16'h0000, "R8 read after reset returns zero");

        write_cmd(7'h5C, 8'h10, a1, a2);
        chk(a1 == 1'b1, "R1 R3 foreign address not acknowledged", a1, 1);
        chk(mode_o == 2'd0, "R3 foreign write ignored", mode_o, 0);

        write_cmd(7'h23, 8'h01, a1, a2);
        chk(a1 == 1'b0 && a2 == 1'b0, "R2 address and data acknowledged", {a1, a2}, 0);
        chk(mode_o == 2'd3, "R7 power-on idle", mode_o, 3);

        sample = 16'hA5C3;
        write_cmd(7'h23, 8'h10, a1, a2);
        chk(mode_o == 2'd1, "R5 continuous mode", mode_o, 1);
        chk(ready_o == 1'b0, "R5 ready cleared by command", ready_o, 0);
        tick(FIRST - 150);
        chk(ready_o == 1'b0, "R5 not ready before first delay", ready_o, 0);
        tick(300);
        chk(ready_o == 1'b1, "R5 ready after first delay", ready_o, 1);
        read_val(7'h23, 16'hA5C3, "R4 R5 first continuous result");

        sample = 16'h1234;
        tick(PER + 100);
        read_val(7'h23, 16'h1234, "R5 continuous refresh");
        chk(mode_o == 2'd1, "R5 stays continuous after read", mode_o, 1);

        write_cmd(7'h23, 8'h47, a1, a2);
        chk(a2 == 1'b0, "R7 unknown command acknowledged", a2, 0);
        chk(mode_o == 2'd1, "R7 unknown command ignored", mode_o, 1);

        write_cmd(7'h23, 8'h00, a1, a2);
        chk(mode_o == 2'd0, "R7 power-down", mode_o, 0);
        sample = 16'h7777;
        tick(PER + 100);
        read_val(7'h23, 16'h1234, "R7 R8 power-down holds last value");

        strap = 1'b1;
        write_cmd(7'h23, 8'h10, a1, a2);
        chk(a1 == 1'b1, "R1 low-strap address rejected when strap high", a1, 1);
        write_cmd(7'h5C, 8'h20, a1, a2);
        chk(a1 == 1'b0, "R1 high-strap address acknowledged", a1, 0);
        chk(mode_o == 2'd2, "R6 one-shot mode", mode_o, 2);
        chk(ready_o == 1'b0, "R6 ready cleared", ready_o, 0);
        read_val(7'h5C, 16'h1234, "R8 early read returns last latched");
        chk(mode_o == 2'd2, "R6 early read keeps one-shot", mode_o, 2);
        tick(FIRST);
        chk(ready_o == 1'b1, "R6 one-shot result ready", ready_o, 1);
        read_val(7'h5C, 16'h7777, "R6 one-shot result");
        chk(mode_o == 2'd0, "R6 auto power-down after read", mode_o, 0);
        sample = 16'h0101;
        tick(FIRST + PER);
        read_val(7'h5C, 16'h7777, "R6 no refresh after one-shot");

        tick(4);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule